// File: doc/BRIEF.md
# SPI Flash Software Command Engine

This block sends one short command to a serial flash device and collects the answer. Software fills an address register and two write-data registers. It then writes a single packed control word that selects the opcode, the optional address, write, dummy and read phases, and the length of each. Setting the execute bit in that same write starts the transfer on a single-lane SPI master interface in clock mode 0. The serial clock runs at a rate fixed by the divider parameter `CLK_DIV`, which is the number of core clocks per half SCLK period.

The transfer always runs its phases in the same order: opcode, address, write data, dummy cycles, read data. A phase is left out when it is not enabled. Bits go out most significant first within each byte. Software polls the in-progress bit in the control word. Once the command is finished, the read-data registers hold up to eight captured bytes, the first byte received in the least significant position.

Top module: `spi_cmd_engine`

## Requirements
- R1: Register addresses are 0 control, 1 address, 2 write data low, 3 write data high, 4 read data low, 5 read data high. Control fields are: opcode 31:24, read enable 23, read count 22:20, address enable 19, address count 17:16, write enable 15, write count 14:12, dummy count 11:7. The stored fields read back at the same positions, and the other bits read 0.
- R2: Writing control with bit 0 set starts a command. Bit 1 of the control readback is 1 from the next cycle until the command is complete, and it falls only after cs_n is high again.
- R3: The number of SCLK rising edges equals 8 plus the bit count of every enabled phase. The opcode goes out first, MSB first.
- R4: When address enable is set, address count plus one bytes are sent from the low bytes of the address register, most significant of those bytes first.
- R5: When write enable is set, write count plus one bytes are sent. Byte k comes from bits 8k+7:8k of the 64-bit write data, where the low register holds bytes 0 to 3. Byte 0 goes first.
- R6: The dummy field gives that many SCLK cycles, with mosi held low, between the write and read phases. A value of 0 gives no dummy cycles.
- R7: When read enable is set, read count plus one bytes are sampled on the rising SCLK edges, MSB first. Received byte k lands in bits 8k+7:8k of the 64-bit read data, and the bytes that were not received read as 0.
- R8: SCLK is low while cs_n is high. The first SCLK rising edge comes 2*CLK_DIV core clocks after cs_n falls. Each SCLK level lasts CLK_DIV core clocks.
- R9: While a command is in progress, writes to the control, address and write-data registers are ignored, including a second execute.
- R10: The read-data registers change only when a command completes with read enable set. Otherwise they keep their value.
- R11: After reset cs_n is high, SCLK and mosi are low, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 3 | Register write address |
| reg_wdata_i | input | 32 | Register write data |
| reg_raddr_i | input | 3 | Register read address |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| sclk_o | output | 1 | SPI serial clock, idle low |
| cs_n_o | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data to the flash |
| miso_i | input | 1 | SPI data from the flash |

## Verification
The bench targets the following corner cases, and what a faulty design would show in each.

- **Phase-length extremes:** an opcode-only command, a 4-byte address with 8 write bytes and 31 dummy cycles, and an 8-byte read. An off-by-one in any count decode changes the number of SCLK edges or shifts every later bit.
- **Read bytes across the register boundary:** a five-byte read. A design that placed bytes in the wrong order, or left stale bytes from an earlier read, returns a wrong upper register.
- **Second execute during a command:** an execute and an address write issued while busy. A design that accepted either would start a second frame or change the address readback.
- **Command without a read:** a design that updated the read registers on every completion would lose the held data.
- **Chip-select lead time:** a wrong lead time shows up in the measured delay from cs_n falling to the first SCLK edge.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [2:0] {
    PH_OPC = 3'd0,
    PH_ADR = 3'd1,
    PH_WR  = 3'd2,
    PH_DMY = 3'd3,
    PH_RD  = 3'd4,
    PH_END = 3'd5
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TRAIL,
    ST_DONE
  } state_e;

  typedef struct packed {
    logic [7:0] opcode;
    logic       rd_en;
    logic [2:0] rd_cnt;
    logic       adr_en;
    logic [1:0] adr_cnt;
    logic       wr_en;
    logic [2:0] wr_cnt;
    logic [4:0] dummy;
  } cmd_t;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_ADDR = 3'd1;
  localparam logic [2:0] RA_WLO  = 3'd2;
  localparam logic [2:0] RA_WHI  = 3'd3;
  localparam logic [2:0] RA_RLO  = 3'd4;
  localparam logic [2:0] RA_RHI  = 3'd5;

  // bit count of one phase
  function automatic logic [7:0] phase_bits(phase_e p, cmd_t c);
    logic [7:0] n;
    case (p)
      PH_OPC:  n = 8'd8;
      PH_ADR:  n = {3'b000, c.adr_cnt, 3'b000} + 8'd8;
      PH_WR:   n = {2'b00, c.wr_cnt, 3'b000} + 8'd8;
      PH_DMY:  n = {3'b000, c.dummy};
      PH_RD:   n = {2'b00, c.rd_cnt, 3'b000} + 8'd8;
      default: n = 8'd0;
    endcase
    return n;
  endfunction

  // first enabled phase after cur, PH_END if none
  function automatic phase_e next_phase(phase_e cur, cmd_t c);
    logic [4:0] en;
    phase_e     res;
    en  = {c.rd_en, (c.dummy != 5'd0), c.wr_en, c.adr_en, 1'b1};
    res = PH_END;
    for (int p = 4; p >= 0; p--) begin
      if ((p > int'(cur)) && en[p]) res = phase_e'(3'(p));
    end
    return res;
  endfunction

endpackage

// File: rtl/spi_cmd_tick.sv
module spi_cmd_tick #(
  parameter int CLK_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (CLK_DIV <= 1) begin : g_nodiv
      assign tick_o = run_i;
    end else begin : g_div
      localparam int CW = $clog2(CLK_DIV);
      localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              cnt_q <= '0;
        else if (!run_i)          cnt_q <= '0;
        else if (cnt_q == LAST)   cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = run_i && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [2:0]  waddr_i,
  input  logic [31:0] wdata_i,
  input  logic [2:0]  raddr_i,
  output logic [31:0] rbus_o,
  input  logic        busy_i,
  input  logic        commit_i,
  input  logic [63:0] rx_i,
  output logic        start_o,
  output cmd_t        cmd_o,
  output logic [31:0] addr_o,
  output logic [63:0] wdata_o,
  output logic [63:0] rx_hold_o
);
  cmd_t        cmd_q;
  logic [31:0] addr_q;
  logic [63:0] wd_q;
  logic [63:0] rx_q;
  logic        wr_ok;

  assign wr_ok   = we_i && !busy_i;
  assign start_o = wr_ok && (waddr_i == RA_CTRL) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (wr_ok) begin
      case (waddr_i)
        RA_CTRL: begin
          cmd_q.opcode  <= wdata_i[31:24];
          cmd_q.rd_en   <= wdata_i[23];
          cmd_q.rd_cnt  <= wdata_i[22:20];
          cmd_q.adr_en  <= wdata_i[19];
          cmd_q.adr_cnt <= wdata_i[17:16];
          cmd_q.wr_en   <= wdata_i[15];
          cmd_q.wr_cnt  <= wdata_i[14:12];
          cmd_q.dummy   <= wdata_i[11:7];
        end
        RA_ADDR: addr_q       <= wdata_i;
        RA_WLO:  wd_q[31:0]   <= wdata_i;
        RA_WHI:  wd_q[63:32]  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      rx_q <= '0;
    else if (commit_i && cmd_q.rd_en) rx_q <= rx_i;
  end

  always_comb begin
    case (raddr_i)
      RA_CTRL: rbus_o = {cmd_q.opcode, cmd_q.rd_en, cmd_q.rd_cnt, cmd_q.adr_en, 1'b0,
                         cmd_q.adr_cnt, cmd_q.wr_en, cmd_q.wr_cnt, cmd_q.dummy,
                         5'b00000, busy_i, 1'b0};
      RA_ADDR: rbus_o = addr_q;
      RA_WLO:  rbus_o = wd_q[31:0];
      RA_WHI:  rbus_o = wd_q[63:32];
      RA_RLO:  rbus_o = rx_q[31:0];
      RA_RHI:  rbus_o = rx_q[63:32];
      default: rbus_o = 32'h0;
    endcase
  end

  assign cmd_o     = cmd_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wd_q;
  assign rx_hold_o = rx_q;
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        tick_i,
  input  cmd_t        cmd_i,
  input  logic [31:0] addr_i,
  input  logic [63:0] wdata_i,
  input  logic        miso_i,
  output logic        sclk_o,
  output logic        cs_n_o,
  output logic        mosi_o,
  output logic        busy_o,
  output logic        commit_o,
  output phase_e      phase_o,
  output logic [63:0] rx_o
);
  state_e      state_q;
  phase_e      phase_q, nxt_phase;
  logic [7:0]  bit_cnt_q;
  logic [63:0] rx_q;
  logic        last_bit;
  logic [2:0]  bsel;
  logic [5:0]  wsel;
  logic [4:0]  asel;
  logic        bit_val;
  logic        shifting;

  assign bsel      = ~bit_cnt_q[2:0];
  assign wsel      = {bit_cnt_q[5:3], bsel};
  assign asel      = {cmd_i.adr_cnt, 3'b111} - bit_cnt_q[4:0];
  assign last_bit  = (bit_cnt_q == phase_bits(phase_q, cmd_i) - 8'd1);
  assign nxt_phase = next_phase(phase_q, cmd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_OPC;
      bit_cnt_q <= '0;
      rx_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_LEAD;
          phase_q   <= PH_OPC;
          bit_cnt_q <= '0;
          rx_q      <= '0;
        end
        ST_LEAD: if (tick_i) state_q <= ST_LOW;
        ST_LOW: if (tick_i) begin
          state_q <= ST_HIGH;
          if (phase_q == PH_RD) rx_q[wsel] <= miso_i;
        end
        ST_HIGH: if (tick_i) begin
          if (last_bit) begin
            if (nxt_phase == PH_END) begin
              state_q <= ST_TRAIL;
            end else begin
              state_q   <= ST_LOW;
              phase_q   <= nxt_phase;
              bit_cnt_q <= '0;
            end
          end else begin
            state_q   <= ST_LOW;
            bit_cnt_q <= bit_cnt_q + 8'd1;
          end
        end
        ST_TRAIL: if (tick_i) state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (phase_q)
      PH_OPC:  bit_val = cmd_i.opcode[bsel];
      PH_ADR:  bit_val = addr_i[asel];
      PH_WR:   bit_val = wdata_i[wsel];
      default: bit_val = 1'b0;
    endcase
  end

  assign shifting = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign mosi_o   = shifting && bit_val;
  assign sclk_o   = (state_q == ST_HIGH);
  assign cs_n_o   = !(shifting || (state_q == ST_LEAD) || (state_q == ST_TRAIL));
  assign busy_o   = (state_q != ST_IDLE);
  assign commit_o = (state_q == ST_DONE);
  assign phase_o  = phase_q;
  assign rx_o     = rx_q;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_waddr_i,
  input  logic [31:0] reg_wdata_i,
  input  logic [2:0]  reg_raddr_i,
  output logic [31:0] reg_rdata_o,
  output logic        sclk_o,
  output logic        cs_n_o,
  output logic        mosi_o,
  input  logic        miso_i
);
  cmd_t        cmd_w;
  logic [31:0] addr_w;
  logic [63:0] wdata_w;
  logic [63:0] rx_w;
  logic [63:0] rx_hold_w;
  logic        start_w;
  logic        busy_w;
  logic        commit_w;
  logic        tick_w;
  phase_e      phase_w;

  spi_cmd_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .waddr_i   (reg_waddr_i),
    .wdata_i   (reg_wdata_i),
    .raddr_i   (reg_raddr_i),
    .rbus_o    (reg_rdata_o),
    .busy_i    (busy_w),
    .commit_i  (commit_w),
    .rx_i      (rx_w),
    .start_o   (start_w),
    .cmd_o     (cmd_w),
    .addr_o    (addr_w),
    .wdata_o   (wdata_w),
    .rx_hold_o (rx_hold_w)
  );

  spi_cmd_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_w),
    .tick_o (tick_w)
  );

  spi_cmd_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_w),
    .tick_i   (tick_w),
    .cmd_i    (cmd_w),
    .addr_i   (addr_w),
    .wdata_i  (wdata_w),
    .miso_i   (miso_i),
    .sclk_o   (sclk_o),
    .cs_n_o   (cs_n_o),
    .mosi_o   (mosi_o),
    .busy_o   (busy_w),
    .commit_o (commit_w),
    .phase_o  (phase_w),
    .rx_o     (rx_w)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sclk_o,
  input logic        cs_n_o,
  input logic        mosi_o,
  input logic        busy_w,
  input logic        commit_w,
  input phase_e      phase_w,
  input cmd_t        cmd_w,
  input logic [31:0] addr_w,
  input logic [63:0] wdata_w,
  input logic [63:0] rx_hold_w
);
  logic [15:0] lead_cnt;
  logic        seen_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lead_cnt  <= '0;
      seen_edge <= 1'b0;
    end else if (cs_n_o) begin
      lead_cnt  <= '0;
      seen_edge <= 1'b0;
    end else begin
      if (!seen_edge) lead_cnt <= lead_cnt + 16'd1;
      if (sclk_o)     seen_edge <= 1'b1;
    end
  end

  assert_sclk_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sclk_o);

  assert_cs_lead_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sclk_o) && !seen_edge) |-> (lead_cnt == 16'(2 * CLK_DIV)));

  assert_busy_after_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_w) |-> ($past(cs_n_o) && cs_n_o));

  assert_frozen_regs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_w |=> ($stable(cmd_w) && $stable(addr_w) && $stable(wdata_w)));

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_hold_w) |-> $past(commit_w));

  assert_dummy_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_w == PH_DMY) |-> !mosi_o);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sclk_o    (sclk_o),
  .cs_n_o    (cs_n_o),
  .mosi_o    (mosi_o),
  .busy_w    (busy_w),
  .commit_w  (commit_w),
  .phase_w   (phase_w),
  .cmd_w     (cmd_w),
  .addr_w    (addr_w),
  .wdata_w   (wdata_w),
  .rx_hold_w (rx_hold_w)
);

// File: tb/spi_cmd_engine_tb_top.sv
module spi_cmd_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  raddr = '0;
  logic [31:0] rdata;
  logic        sclk, cs_n, mosi, miso;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_engine #(.CLK_DIV(CLK_DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
    .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  // flash model: records mosi, serves miso from a random stream
  logic [255:0] stream;
  logic         got [256];
  logic [8:0]   idx = '0;
  int           cs_falls = 0;
  longint       t_cs = 0, t_rise = 0;

  assign miso = stream[idx[7:0]];

  always @(negedge cs_n or posedge sclk) begin
    if (sclk) begin
      if (idx == 9'd0) t_rise = $time;
      got[idx[7:0]] = mosi;
      idx = idx + 9'd1;
    end else begin
      idx = '0;
      cs_falls++;
      t_cs = $time;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    raddr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [63:0] grab_got(int st, int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r = {r[62:0], got[st+i]};
    return r;
  endfunction

  function automatic logic [63:0] grab_stream(int st, int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r = {r[62:0], stream[st+i]};
    return r;
  endfunction

  function automatic logic [31:0] mk_ctrl(logic [7:0] op, logic ren, logic [2:0] rc,
      logic aen, logic [1:0] ac, logic wen, logic [2:0] wc, logic [4:0] dmy);
    return {op, ren, rc, aen, 1'b0, ac, wen, wc, dmy, 7'b0};
  endfunction

  // current command
  logic [7:0]  c_op;
  logic        c_aen, c_wen, c_ren;
  logic [1:0]  c_ac;
  logic [2:0]  c_wc, c_rc;
  logic [4:0]  c_dmy;
  logic [31:0] c_addr;
  logic [63:0] c_wd;
  logic [63:0] prev_rd = '0;
  int          falls_before;

  task automatic start_cmd();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) stream[i*32 +: 32] = $urandom;
    reg_wr(3'd1, c_addr);
    reg_wr(3'd2, c_wd[31:0]);
    reg_wr(3'd3, c_wd[63:32]);
    falls_before = cs_falls;
    reg_wr(3'd0, mk_ctrl(c_op, c_ren, c_rc, c_aen, c_ac, c_wen, c_wc, c_dmy) | 32'h1);
    reg_rd(3'd0, d);
    check("R2 busy bit", {63'b0, d[1]}, 64'd1);
  endtask

  task automatic wait_done();
    logic [31:0] d;
    for (int i = 0; i < 5000; i++) begin
      reg_rd(3'd0, d);
      if (!d[1]) break;
    end
  endtask

  task automatic verify();
    int na, nw, nr, s, tot;
    logic [31:0] d, lo, hi;
    logic [63:0] exp_w, exp_r;
    na  = c_aen ? 8*(int'(c_ac)+1) : 0;
    nw  = c_wen ? 8*(int'(c_wc)+1) : 0;
    nr  = c_ren ? 8*(int'(c_rc)+1) : 0;
    s   = 8 + na + nw + int'(c_dmy);
    tot = s + nr;
    check("R3 edge count", 64'(idx), 64'(tot));
    check("R9 one frame", 64'(cs_falls - falls_before), 64'd1);
    check("R3 opcode", grab_got(0, 8), 64'(c_op));
    if (c_aen) check("R4 address", grab_got(8, na), 64'(c_addr) & ((64'd1 << na) - 64'd1));
    if (c_wen) begin
      exp_w = '0;
      for (int k = 0; k <= int'(c_wc); k++) exp_w = {exp_w[55:0], c_wd[8*k +: 8]};
      check("R5 write data", grab_got(8 + na, nw), exp_w);
    end
    if (c_dmy != 0) check("R6 dummy low", grab_got(8 + na + nw, int'(c_dmy)), 64'd0);
    check("R8 cs lead", 64'(t_rise - t_cs), 64'(2*CLK_DIV*CLK_PERIOD));
    if (c_ren) begin
      exp_r = '0;
      for (int j = 0; j <= int'(c_rc); j++) exp_r[8*j +: 8] = grab_stream(s + 8*j, 8)[7:0];
    end else begin
      exp_r = prev_rd;
    end
    reg_rd(3'd4, lo);
    reg_rd(3'd5, hi);
    check(c_ren ? "R7 read data" : "R10 read hold", {hi, lo}, exp_r);
    prev_rd = {hi, lo};
    reg_rd(3'd0, d);
    check("R1 ctrl readback", 64'(d), 64'(mk_ctrl(c_op, c_ren, c_rc, c_aen, c_ac, c_wen, c_wc, c_dmy)));
    check("R8 idle lines", {62'b0, cs_n, sclk}, 64'd2);
  endtask

  task automatic run_cmd();
    start_cmd();
    wait_done();
    verify();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    stream = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 pins", {61'b0, cs_n, sclk, mosi}, 64'd4);
    for (int a = 0; a < 6; a++) begin
      reg_rd(3'(a), d);
      check("R11 reg zero", 64'(d), 64'd0);
    end
    // R1 control fields without execute
    reg_wr(3'd0, 32'hFFFF_FFFE);
    reg_rd(3'd0, d);
    check("R1 field mask", 64'(d), 64'hFFFB_FF80);
    check("R2 no start", 64'(cs_falls), 64'd0);

    // opcode only
    c_op = 8'h9F; c_aen = 0; c_ac = 0; c_wen = 0; c_wc = 0; c_dmy = 0; c_ren = 0; c_rc = 0;
    c_addr = 32'h0; c_wd = 64'h0;
    run_cmd();
    // 3-byte address, 8-byte read
    c_op = 8'h0B; c_aen = 1; c_ac = 2; c_dmy = 8; c_ren = 1; c_rc = 7;
    c_addr = 32'hA5C3_1234;
    run_cmd();
    // 4-byte address, 8 write bytes, 31 dummy, 1 read byte
    c_op = 8'h5A; c_aen = 1; c_ac = 3; c_wen = 1; c_wc = 7; c_dmy = 31; c_ren = 1; c_rc = 0;
    c_addr = 32'h8001_7FFE; c_wd = 64'h0123_4567_89AB_CDEF;
    run_cmd();
    // five read bytes across the register boundary
    c_op = 8'h05; c_aen = 0; c_wen = 0; c_dmy = 0; c_ren = 1; c_rc = 4;
    run_cmd();
    // no read: R10 hold
    c_op = 8'h06; c_ren = 0; c_wen = 1; c_wc = 2; c_wd = 64'hDEAD_BEEF_CAFE_F00D;
    run_cmd();

    // R9: execute and address write while busy are ignored
    c_op = 8'h3C; c_aen = 1; c_ac = 1; c_wen = 0; c_dmy = 12; c_ren = 1; c_rc = 7;
    c_addr = 32'h0000_BEEF;
    start_cmd();
    reg_wr(3'd1, 32'h1111_2222);
    reg_wr(3'd0, mk_ctrl(8'hC3, 0, 0, 0, 0, 0, 0, 0) | 32'h1);
    wait_done();
    reg_rd(3'd1, d);
    check("R9 addr kept", 64'(d), 64'(c_addr));
    verify();
    repeat (4 * CLK_DIV + 4) @(negedge clk);
    check("R9 no second frame", 64'(cs_falls - falls_before), 64'd1);

    // random commands
    for (int n = 0; n < 24; n++) begin
      c_op   = 8'($urandom);
      c_aen  = 1'($urandom);
      c_ac   = 2'($urandom);
      c_wen  = 1'($urandom);
      c_wc   = 3'($urandom);
      c_dmy  = ($urandom % 3 == 0) ? 5'd0 : 5'($urandom);
      c_ren  = 1'($urandom);
      c_rc   = 3'($urandom);
      c_addr = $urandom;
      c_wd   = {$urandom, $urandom};
      run_cmd();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule